// File: doc/BRIEF.md
# Multiplexed System Bus Master

This block is the processor-side end of a system bus that carries an address phase and then a data phase over one shared 64-bit address/data bus. A 9-bit command/identifier bus and an 8-bit byte-check bus run beside it. An internal requester presents one read or write at a time on a simple valid/acknowledge port. The block waits for the external agent's flow-control strobe for that kind of request, then drives the bus. It reports completion with a one-cycle acknowledge.

Bus ownership moves by an explicit release handshake. The agent can ask for the bus at any idle moment. The block also hands the bus over by itself after every read address phase, so that the agent can return the read word. That word is taken only in a cycle where the agent's valid-input strobe is low. Every transaction carries one read word at most. After each hand-over the block spends one cycle with release deasserted and its drivers off before it drives again. All strobes on the bus side are active low.

Top module: `sysbus_master`

## Requirements
- R1: After reset, releaseN and validOutN are high, busOe is low and reqAck and rdValid are low.
- R2: A write drives exactly one address cycle and then one data cycle, both with validOutN low and busOe high. In the address cycle cmdOut[8]=0, cmdOut[7]=1 and cmdOut[6]=double. In the data cycle cmdOut[8]=1 and cmdOut[7]=1. reqAck pulses for one cycle in the cycle after the data cycle.
- R3: A read address phase starts only on a clock edge where rdRdyN is low. A write address phase starts only on a clock edge where wrRdyN is low. A request with its ready strobe high waits with the bus idle.
- R4: A read drives one address cycle with cmdOut[8]=0 and cmdOut[7]=0. From the next cycle, releaseN is low and busOe is low until validInN is sampled low. The sampled word appears on rdData with rdValid and reqAck high for one cycle. That cycle has releaseN high and busOe low.
- R5: When extRqstN is sampled low while idle, releaseN goes low in the next cycle and busOe stays low. Both hold as long as extRqstN stays low. This takes priority over a pending internal request. After extRqstN rises, one cycle follows with releaseN high and the bus undriven before any new address phase.
- R6: For a double-word access (reqDouble=1) the address phase drives busAdOut[2:0] as zero. A single access drives the address unchanged.
- R7: In a write data cycle, chkOut[b] equals the XOR of busAdOut byte b (even parity per byte, byte b = bits 8b+7..8b).
- R8: rdParityErr is high with rdValid when any used byte of the received word disagrees with its chkIn bit under even parity.
- R9: With mode32 high, busAdOut[63:32] and chkOut[7:4] are zero, rdData[63:32] is zero, and parity mismatches in bytes 4..7 do not raise rdParityErr.
- R10: cmdParity is always low.
- R11: validInN low outside the read-response wait has no effect: rdValid and reqAck stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mode32 | input | 1 | 1 = only low 32 bits and low 4 check bits used |
| reqValid | input | 1 | Internal request present, held until reqAck |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqDouble | input | 1 | Double-word access |
| reqAddr | input | 36 | Request address |
| reqData | input | 64 | Write data |
| reqAck | output | 1 | One-cycle completion pulse |
| rdData | output | 64 | Returned read word |
| rdValid | output | 1 | rdData valid this cycle |
| rdParityErr | output | 1 | Check-bit mismatch on returned word |
| extRqstN | input | 1 | Agent requests the bus (active low) |
| releaseN | output | 1 | Bus handed to agent (active low) |
| rdRdyN | input | 1 | Agent can take a read (active low) |
| wrRdyN | input | 1 | Agent can take a write (active low) |
| validInN | input | 1 | Agent drives valid word (active low) |
| validOutN | output | 1 | Block drives valid word (active low) |
| busAdOut | output | 64 | Address/data driven value |
| busAdIn | input | 64 | Address/data received value |
| busOe | output | 1 | Enable for busAdOut, chkOut, cmdOut |
| chkOut | output | 8 | Byte check bits driven |
| chkIn | input | 8 | Byte check bits received |
| cmdOut | output | 9 | Command/identifier driven |
| cmdIn | input | 9 | Command/identifier received |
| cmdParity | output | 1 | Command parity, tied low |

## Verification
Several rules are checked by the assertions on every cycle. Release and the drivers are never on together, and valid-out and release never coincide. Each address phase is checked against the ready strobe for its direction. The checks also cover alignment zeros, driven parity, the upper half being zero in 32-bit mode, and the write data cycle that follows its address cycle. Other behaviour needs the bench's scenarios. These are the order and exact cycle of the acknowledge, the word returned and its error flag, priority of the agent over a pending request, and the undriven gap after each hand-back.

// File: rtl/sysbus_pkg.sv
package sysbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_WDATA, ST_RDWAIT, ST_GRANT, ST_REGAIN
  } busState_t;

  typedef struct packed {
    logic latchReq;
    logic driveAddr;
    logic driveData;
    logic captureRd;
  } ctrlStrobes_t;
endpackage

// File: rtl/sysbus_ctrl.sv
module sysbus_ctrl
  import sysbus_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqWrite,
  input  logic         extRqstN,
  input  logic         rdRdyN,
  input  logic         wrRdyN,
  input  logic         validInN,
  output ctrlStrobes_t strobes,
  output logic         releaseN,
  output logic         validOutN,
  output logic         busOe,
  output logic         reqAck
);
  busState_t state, stateNext;
  logic      ackQ;
  logic      curWrite;
  logic      issueRd, issueWr;

  assign issueRd = reqValid && !reqWrite && !rdRdyN && !ackQ;
  assign issueWr = reqValid &&  reqWrite && !wrRdyN && !ackQ;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (!extRqstN)               stateNext = ST_GRANT;
                 else if (issueRd || issueWr) stateNext = ST_ADDR;
      ST_ADDR:   stateNext = curWrite ? ST_WDATA : ST_RDWAIT;
      ST_WDATA:  stateNext = ST_IDLE;
      ST_RDWAIT: if (!validInN)              stateNext = ST_REGAIN;
      ST_GRANT:  if (extRqstN)               stateNext = ST_REGAIN;
      ST_REGAIN: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      ackQ     <= 1'b0;
      curWrite <= 1'b0;
    end else begin
      state <= stateNext;
      ackQ  <= (state == ST_WDATA) || (state == ST_RDWAIT && !validInN);
      if (state == ST_IDLE && extRqstN && (issueRd || issueWr))
        curWrite <= reqWrite;
    end
  end

  always_comb begin
    strobes.latchReq  = (state == ST_IDLE) && extRqstN && (issueRd || issueWr);
    strobes.driveAddr = (state == ST_ADDR);
    strobes.driveData = (state == ST_WDATA);
    strobes.captureRd = (state == ST_RDWAIT) && !validInN;
  end

  assign releaseN  = !(state == ST_RDWAIT || state == ST_GRANT);
  assign busOe     = (state == ST_ADDR) || (state == ST_WDATA);
  assign validOutN = !busOe;
  assign reqAck    = ackQ;
endmodule

// File: rtl/sysbus_dpath.sv
module sysbus_dpath
  import sysbus_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 36,
  parameter int CMD_W  = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mode32,
  input  ctrlStrobes_t      strobes,
  input  logic              reqWrite,
  input  logic              reqDouble,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [DATA_W-1:0] busAdIn,
  input  logic [DATA_W/8-1:0] chkIn,
  output logic [DATA_W-1:0] busAdOut,
  output logic [DATA_W/8-1:0] chkOut,
  output logic [CMD_W-1:0]  cmdOut,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              rdParityErr
);
  localparam int CHK_W  = DATA_W / 8;
  localparam int HALF_W = DATA_W / 2;
  localparam int HALF_C = CHK_W / 2;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic              writeQ, doubleQ;
  logic [DATA_W-1:0] laneMask;
  logic [CHK_W-1:0]  chkMask, parOut, parIn;
  logic [DATA_W-1:0] addrWord, maskedIn;

  for (genvar b = 0; b < CHK_W; b++) begin : g_lane
    assign chkMask[b] = !mode32 || (b < HALF_C);
    assign laneMask[8*b +: 8] = {8{chkMask[b]}};
    assign parOut[b] = ^dataQ[8*b +: 8];
    assign parIn[b]  = ^busAdIn[8*b +: 8];
  end

  assign maskedIn = busAdIn & laneMask;

  always_comb begin
    addrWord = '0;
    addrWord[ADDR_W-1:0] = addrQ;
    if (doubleQ) addrWord[2:0] = 3'b000;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0; dataQ <= '0; writeQ <= 1'b0; doubleQ <= 1'b0;
      rdData <= '0; rdValid <= 1'b0; rdParityErr <= 1'b0;
    end else begin
      if (strobes.latchReq) begin
        addrQ   <= reqAddr;
        dataQ   <= reqData;
        writeQ  <= reqWrite;
        doubleQ <= reqDouble;
      end
      rdValid <= strobes.captureRd;
      if (strobes.captureRd) begin
        rdData      <= maskedIn;
        rdParityErr <= |((parIn ^ chkIn) & chkMask);
      end else begin
        rdParityErr <= 1'b0;
      end
    end
  end

  always_comb begin
    busAdOut = '0;
    chkOut   = '0;
    cmdOut   = '0;
    if (strobes.driveAddr) begin
      busAdOut       = addrWord & laneMask;
      cmdOut[CMD_W-1] = 1'b0;
      cmdOut[CMD_W-2] = writeQ;
      cmdOut[CMD_W-3] = doubleQ;
    end else if (strobes.driveData) begin
      busAdOut        = dataQ & laneMask;
      chkOut          = parOut & chkMask;
      cmdOut[CMD_W-1] = 1'b1;
      cmdOut[CMD_W-2] = 1'b1;
    end
  end

  logic unusedHalf;
  assign unusedHalf = ^HALF_W;
endmodule

// File: rtl/sysbus_master.sv
module sysbus_master
  import sysbus_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        mode32,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        reqDouble,
  input  logic [35:0] reqAddr,
  input  logic [63:0] reqData,
  output logic        reqAck,
  output logic [63:0] rdData,
  output logic        rdValid,
  output logic        rdParityErr,
  input  logic        extRqstN,
  output logic        releaseN,
  input  logic        rdRdyN,
  input  logic        wrRdyN,
  input  logic        validInN,
  output logic        validOutN,
  output logic [63:0] busAdOut,
  input  logic [63:0] busAdIn,
  output logic        busOe,
  output logic [7:0]  chkOut,
  input  logic [7:0]  chkIn,
  output logic [8:0]  cmdOut,
  input  logic [8:0]  cmdIn,
  output logic        cmdParity
);
  ctrlStrobes_t strobes;

  sysbus_ctrl ctrl_i (
    .clk, .rstN, .reqValid, .reqWrite, .extRqstN, .rdRdyN, .wrRdyN,
    .validInN, .strobes, .releaseN, .validOutN, .busOe, .reqAck
  );

  sysbus_dpath #(.DATA_W(64), .ADDR_W(36), .CMD_W(9)) dpath_i (
    .clk, .rstN, .mode32, .strobes, .reqWrite, .reqDouble, .reqAddr,
    .reqData, .busAdIn, .chkIn, .busAdOut, .chkOut, .cmdOut, .rdData,
    .rdValid, .rdParityErr
  );

  logic unusedCmd;
  assign unusedCmd = ^cmdIn;
  assign cmdParity = 1'b0;
endmodule

// File: rtl/sysbus_master_chk.sv
module sysbus_master_chk (
  input logic        clk,
  input logic        rstN,
  input logic        mode32,
  input logic        rdRdyN,
  input logic        wrRdyN,
  input logic        releaseN,
  input logic        validOutN,
  input logic        busOe,
  input logic [63:0] busAdOut,
  input logic [7:0]  chkOut,
  input logic [8:0]  cmdOut,
  input logic        cmdParity
);
  logic addrRd, addrWr, dataCyc;
  assign addrRd  = !validOutN && !cmdOut[8] && !cmdOut[7];
  assign addrWr  = !validOutN && !cmdOut[8] &&  cmdOut[7];
  assign dataCyc = !validOutN &&  cmdOut[8];

  assert_no_drive_when_released_R5: assert property (@(posedge clk) disable iff (!rstN)
    !releaseN |-> (!busOe && validOutN));
  assert_read_gated_R3: assert property (@(posedge clk) disable iff (!rstN)
    addrRd |-> $past(!rdRdyN));
  assert_write_gated_R3: assert property (@(posedge clk) disable iff (!rstN)
    addrWr |-> $past(!wrRdyN));
  assert_write_data_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    addrWr |=> dataCyc);
  assert_read_releases_R4: assert property (@(posedge clk) disable iff (!rstN)
    addrRd |=> (!releaseN && !busOe));
  assert_double_aligned_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!validOutN && !cmdOut[8] && cmdOut[6]) |-> (busAdOut[2:0] == 3'b000));
  assert_data_parity_R7: assert property (@(posedge clk) disable iff (!rstN)
    dataCyc |-> (chkOut[0] == ^busAdOut[7:0] && chkOut[3] == ^busAdOut[31:24]));
  assert_upper_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    mode32 |-> (busAdOut[63:32] == '0 && chkOut[7:4] == '0));
  assert_cmd_parity_low_R10: assert property (@(posedge clk) disable iff (!rstN)
    !cmdParity);
endmodule

bind sysbus_master sysbus_master_chk chk_i (
  .clk(clk), .rstN(rstN), .mode32(mode32), .rdRdyN(rdRdyN), .wrRdyN(wrRdyN),
  .releaseN(releaseN), .validOutN(validOutN), .busOe(busOe),
  .busAdOut(busAdOut), .chkOut(chkOut), .cmdOut(cmdOut), .cmdParity(cmdParity)
);

// File: tb/sysbus_master_tb.sv
module sysbus_master_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        mode32 = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqDouble = 1'b0;
  logic [35:0] reqAddr = '0;
  logic [63:0] reqData = '0;
  logic        reqAck, rdValid, rdParityErr;
  logic [63:0] rdData;
  logic        extRqstN = 1'b1, rdRdyN = 1'b1, wrRdyN = 1'b1, validInN = 1'b1;
  logic        releaseN, validOutN, busOe, cmdParity;
  logic [63:0] busAdOut, busAdIn = '0;
  logic [7:0]  chkOut, chkIn = '0;
  logic [8:0]  cmdOut, cmdIn = '0;

  int nChecks = 0, nFails = 0;

  always #10 clk = ~clk;

  sysbus_master dut_i (.*);

  function automatic logic [7:0] evenPar(input logic [63:0] w);
    for (int b = 0; b < 8; b++) evenPar[b] = ^w[8*b +: 8];
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic doWrite(input logic dbl, input logic [35:0] a, input logic [63:0] d);
    reqValid = 1; reqWrite = 1; reqDouble = dbl; reqAddr = a; reqData = d;
    wrRdyN = 1;
    step(); step();
    check("R3 write held while wrRdyN high", {busOe, validOutN}, 2'b01);
    wrRdyN = 0;
    step();
    check("R2 addr cycle strobes", {busOe, validOutN, releaseN}, 3'b101);
    check("R2 addr cmd", cmdOut[8:6], {2'b01, dbl});
    check("R6 address value", busAdOut,
          mode32 ? {32'b0, a[31:3], dbl ? 3'b000 : a[2:0]} : {28'b0, a[35:3], dbl ? 3'b000 : a[2:0]});
    check("R10 cmd parity", cmdParity, 0);
    step();
    check("R2 data cycle strobes", {busOe, validOutN, reqAck}, 3'b100);
    check("R2 data cmd", cmdOut[8:7], 2'b11);
    check("R2/R9 data value", busAdOut, mode32 ? {32'b0, d[31:0]} : d);
    check("R7 data parity", chkOut, mode32 ? {4'b0, evenPar(d)[3:0]} : evenPar(d));
    step();
    check("R2 ack after data", {reqAck, busOe}, 2'b10);
    reqValid = 0; wrRdyN = 1;
    step();
    check("R2 ack single cycle", {reqAck, busOe}, 2'b00);
  endtask

  task automatic doRead(input logic [35:0] a, input logic [63:0] d, input logic [7:0] chk,
                        input logic expErr);
    reqValid = 1; reqWrite = 0; reqDouble = 0; reqAddr = a; rdRdyN = 1;
    step();
    check("R3 read held while rdRdyN high", {busOe, releaseN}, 2'b01);
    rdRdyN = 0;
    step();
    check("R4 read addr cycle", {busOe, validOutN, cmdOut[8:7]}, 4'b1000);
    rdRdyN = 1;
    step();
    check("R4 released, undriven", {releaseN, busOe}, 2'b00);
    step();
    check("R4 still waiting", {releaseN, busOe, rdValid}, 3'b000);
    validInN = 0; busAdIn = d; chkIn = chk;
    step();
    validInN = 1;
    check("R4 read return strobes", {rdValid, reqAck, releaseN, busOe}, 4'b1110);
    check("R4/R9 read data", rdData, mode32 ? {32'b0, d[31:0]} : d);
    check("R8 parity error flag", rdParityErr, expErr);
    reqValid = 0;
    step();
    check("R4 single pulse", {rdValid, reqAck}, 2'b00);
  endtask

  task automatic doExtGrant();
    reqValid = 1; reqWrite = 1; wrRdyN = 0; extRqstN = 0;
    step();
    check("R5 grant over pending write", {releaseN, busOe}, 2'b00);
    step(); step();
    check("R5 hold while requested", {releaseN, busOe}, 2'b00);
    extRqstN = 1;
    step();
    check("R5 regain gap", {releaseN, busOe}, 2'b10);
    step();
    check("R5 idle before drive", busOe, 0);
    step();
    check("R5 pending write then starts", {busOe, cmdOut[8:7]}, 3'b101);
    step(); step();
    check("R5 pending write acked", reqAck, 1);
    reqValid = 0; wrRdyN = 1;
    step();
  endtask

  task automatic strayValidIn();
    validInN = 0; busAdIn = 64'hDEAD;
    step(); step();
    check("R11 stray validIn ignored", {rdValid, reqAck, releaseN}, 3'b001);
    validInN = 1;
  endtask

  initial begin
    #3000000;
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R1 reset state", {releaseN, validOutN, busOe, reqAck, rdValid}, 5'b11000);
    rstN = 1;
    step();
    check("R1 after reset", {releaseN, validOutN, busOe}, 3'b110);
    doWrite(1'b0, 36'h9_1234_5677, 64'h0123_4567_89AB_CDEF);
    doWrite(1'b1, 36'hA_BCDE_F017, 64'hFFFF_0000_8001_7E11);
    doRead(36'h3_0000_0100, 64'h1122_3344_5566_7788, evenPar(64'h1122_3344_5566_7788), 1'b0);
    doRead(36'h3_0000_0108, 64'h1122_3344_5566_7788,
           evenPar(64'h1122_3344_5566_7788) ^ 8'h40, 1'b1);
    doExtGrant();
    strayValidIn();
    mode32 = 1;
    doWrite(1'b0, 36'hF_8765_4321, 64'hCAFE_BABE_1357_9BDF);
    doRead(36'h0_0000_0040, 64'h5A5A_A5A5_0F0F_F0F0,
           evenPar(64'h5A5A_A5A5_0F0F_F0F0) ^ 8'h80, 1'b0);
    doRead(36'h0_0000_0048, 64'h5A5A_A5A5_0F0F_F0F0,
           evenPar(64'h5A5A_A5A5_0F0F_F0F0) ^ 8'h02, 1'b1);
    check("R10 cmd parity at end", cmdParity, 0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule